// File: doc/BRIEF.md
# Calibrated completion interrupt coalescer

This block decides when a completion queue signals the host. It sits next to the queue and sees one pulse for each completion the queue accepts. The pulse comes with a two-bit hint that was attached to the request when it was submitted. The block counts completions that have not yet been signalled. It can raise its interrupt for four reasons: the count reaches a programmed threshold, a coarse aggregation timer runs out, a completion arrives while coalescing is switched off, or the hint says the host is waiting for that request.

Time is counted in coarse units. An external strobe marks the end of each unit, and the timer counts whole strobes. Every interrupt covers all completions pending at that moment, so the count and the timer both return to zero when it fires. The interrupt is a level. It stays asserted until the host pulses an acknowledge. Completions that arrive while the level is high begin a new batch.

Top module: `cq_irq_calibrator`

## Requirements
- R1: While reset is asserted and right after it, `irq` is 0. Reset leaves the threshold and the timeout at 0, so coalescing starts out off.
- R2: While the threshold is 0 or 1, every accepted completion sets `irq` at the clock edge that takes it, whatever its hint.
- R3: With a threshold T of 2 or more, `irq` rises at the edge that takes the T-th pending completion whose hint is 2'b00. It does not rise earlier for count reasons.
- R4: With a timeout U of 1 or more, `irq` rises at the edge that takes the U-th `unit_tick`. Ticks count only in cycles where the pending count was already non-zero before that edge.
- R5: A completion with hint 2'b01 or 2'b11 sets `irq` at the edge that takes it, even while coalescing.
- R6: A completion with hint 2'b10 sets `irq` at the edge that takes it and flushes the pending batch.
- R7: Any interrupt clears the pending count and the timer, so the next count-triggered interrupt needs T new completions.
- R8: Once set, `irq` stays 1 until a cycle with `irq_ack` high and no new firing cause. In that case it drops at that edge. A firing cause in the same cycle as `irq_ack` keeps `irq` at 1.
- R9: A `cfg_wr` is accepted only while the pending count is 0. Otherwise it has no effect on the threshold or the timeout.
- R10: A timeout of 0 turns the timer off. Pending completions then wait for the threshold or an urgent hint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmpl_valid | input | 1 | One completion accepted this cycle |
| cmpl_tag | input | 2 | Latency hint of that completion (00 coalesce, 01/11 urgent, 10 batch end) |
| unit_tick | input | 1 | One-cycle strobe at the end of each coarse time unit |
| cfg_wr | input | 1 | Load threshold and timeout |
| cfg_thresh | input | CNT_W | Completion count threshold (0 or 1 = coalescing off) |
| cfg_units | input | TMR_W | Aggregation timeout in units (0 = no timeout) |
| irq_ack | input | 1 | One-cycle host acknowledge |
| irq | output | 1 | Interrupt level |

## Verification
The embedded assertions check four properties on every cycle. The pending count stays below an active threshold. Urgent hints and completions taken while coalescing is off are followed by `irq`. The level holds without an acknowledge. A refused configuration write leaves the settings unchanged. The timer staying at zero while nothing is pending is also checked every cycle. Two behaviours are shown only by the bench's scenarios, which compare `irq` every cycle with a model: exact firing edges after the T-th completion or the U-th tick, and the fact that a fresh batch needs the full count again after a flush.

// File: rtl/cq_irq_pkg.sv
package cq_irq_pkg;
  typedef enum logic [1:0] {
    HINT_COALESCE = 2'b00,
    HINT_URGENT   = 2'b01,
    HINT_FLUSH    = 2'b10,
    HINT_URGENT_X = 2'b11
  } cmpl_hint_e;

  function automatic logic hint_is_immediate(input cmpl_hint_e h);
    return h != HINT_COALESCE;
  endfunction
endpackage

// File: rtl/cq_irq_cfg.sv
module cq_irq_cfg #(
  parameter int CNT_W = 8,
  parameter int TMR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             idle,
  input  logic [CNT_W-1:0] thr_in,
  input  logic [TMR_W-1:0] units_in,
  output logic [CNT_W-1:0] thr_q,
  output logic [TMR_W-1:0] units_q,
  output logic             coal_en,
  output logic             tmo_en
);
  logic             load;
  logic [CNT_W-1:0] thr_d;
  logic [TMR_W-1:0] units_d;

  always_comb begin
    load    = wr && idle;
    thr_d   = thr_q;
    units_d = units_q;
    if (load) begin
      thr_d   = thr_in;
      units_d = units_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= '0;
      units_q <= '0;
    end else if (load) begin
      thr_q   <= thr_d;
      units_q <= units_d;
    end
  end

  assign coal_en = thr_q > CNT_W'(1);
  assign tmo_en  = units_q != '0;

  // R9
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !idle) |=> ($stable(thr_q) && $stable(units_q)));
endmodule

// File: rtl/cq_irq_batch.sv
module cq_irq_batch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic             coal_en,
  input  logic [CNT_W-1:0] thr,
  output logic             busy,
  output logic             thr_hit
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] pend_q;
  logic [CNT_W-1:0] pend_d;
  logic [EXT_W-1:0] pend_inc;

  assign pend_inc = {1'b0, pend_q} + EXT_W'(1);
  assign thr_hit  = inc && (pend_inc >= {1'b0, thr});
  assign busy     = pend_q != '0;

  always_comb begin
    pend_d = pend_q;
    if (clr)      pend_d = '0;
    else if (inc) pend_d = pend_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pend_q <= '0;
    else if (clr || inc) pend_q <= pend_d;
  end

  // R3
  below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coal_en |-> (pend_q < thr));
  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pend_q == '0));
endmodule

// File: rtl/cq_irq_timer.sv
module cq_irq_timer #(
  parameter int TMR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             clr,
  input  logic             tmo_en,
  input  logic [TMR_W-1:0] units,
  output logic             expire
);
  localparam int EXT_W = TMR_W + 1;

  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] tmr_d;
  logic [EXT_W-1:0] tmr_inc;
  logic             step;

  assign step    = run && tick;
  assign tmr_inc = {1'b0, tmr_q} + EXT_W'(1);
  assign expire  = step && tmo_en && (tmr_inc >= {1'b0, units});

  always_comb begin
    tmr_d = tmr_q;
    if (clr)       tmr_d = '0;
    else if (step) tmr_d = tmr_inc[TMR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tmr_q <= '0;
    else if (clr || step) tmr_q <= tmr_d;
  end

  // R4
  idle_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (tmr_q == '0));
endmodule

// File: rtl/cq_irq_calibrator.sv
module cq_irq_calibrator
  import cq_irq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmpl_valid,
  input  logic [1:0]       cmpl_tag,
  input  logic             unit_tick,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_thresh,
  input  logic [TMR_W-1:0] cfg_units,
  input  logic             irq_ack,
  output logic             irq
);
  logic [CNT_W-1:0] thr;
  logic [TMR_W-1:0] units;
  logic             coal_en, tmo_en, busy, thr_hit, expire;
  logic             now_fire, fire;
  logic             irq_q, irq_d;
  cmpl_hint_e       hint;

  assign hint = cmpl_hint_e'(cmpl_tag);

  cq_irq_cfg #(.CNT_W(CNT_W), .TMR_W(TMR_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idle(!busy),
    .thr_in(cfg_thresh), .units_in(cfg_units),
    .thr_q(thr), .units_q(units), .coal_en(coal_en), .tmo_en(tmo_en));

  cq_irq_batch #(.CNT_W(CNT_W)) i_batch (
    .clk(clk), .rst_n(rst_n), .inc(cmpl_valid), .clr(fire),
    .coal_en(coal_en), .thr(thr), .busy(busy), .thr_hit(thr_hit));

  cq_irq_timer #(.TMR_W(TMR_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(unit_tick), .clr(fire),
    .tmo_en(tmo_en), .units(units), .expire(expire));

  assign now_fire = cmpl_valid && (hint_is_immediate(hint) || !coal_en);
  assign fire     = now_fire || thr_hit || expire;

  always_comb begin
    irq_d = irq_q;
    if (fire)         irq_d = 1'b1;
    else if (irq_ack) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                irq_q <= 1'b0;
    else if (fire || irq_ack)  irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R5
  urgent_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && cmpl_tag != 2'b00) |=> irq);
  // R2
  uncoalesced_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && !coal_en) |=> irq);
  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);
endmodule

// File: tb/test_cq_irq_calibrator.sv
`timescale 1ns/1ps
module test_cq_irq_calibrator;
  localparam int CNT_W = 8;
  localparam int TMR_W = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic cmpl_valid, unit_tick, cfg_wr, irq_ack, irq;
  logic [1:0] cmpl_tag;
  logic [CNT_W-1:0] cfg_thresh;
  logic [TMR_W-1:0] cfg_units;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int m_thr, m_units, m_pend, m_tmr;
  bit m_irq;

  always #2.5 clk = ~clk;

  cq_irq_calibrator #(.CNT_W(CNT_W), .TMR_W(TMR_W)) i_cq_irq_calibrator (
    .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
    .unit_tick(unit_tick), .cfg_wr(cfg_wr), .cfg_thresh(cfg_thresh),
    .cfg_units(cfg_units), .irq_ack(irq_ack), .irq(irq));

  function automatic bit fires(int thr, int un, int pend, int tmr,
                               bit v, int tag, bit tick);
    bit coal = thr >= 2;
    if (v && (tag != 0 || !coal || pend + 1 >= thr)) return 1;
    if (pend != 0 && un != 0 && tick && tmr + 1 >= un) return 1;
    return 0;
  endfunction

  task automatic check(string req, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(string req, bit v, int tag, bit tick, bit ack,
                     bit wr = 0, int thr = 0, int un = 0);
    bit f;
    cmpl_valid = v; cmpl_tag = 2'(tag); unit_tick = tick; irq_ack = ack;
    cfg_wr = wr; cfg_thresh = CNT_W'(thr); cfg_units = TMR_W'(un);
    f = fires(m_thr, m_units, m_pend, m_tmr, v, tag, tick);
    if (wr && m_pend == 0) begin
      // apply after firing decision: decision used old settings
    end
    if (f) begin
      m_irq = 1; m_tmr = 0;
      if (wr && m_pend == 0) begin m_thr = thr; m_units = un; end
      m_pend = 0;
    end else begin
      if (tick && m_pend != 0) m_tmr++;
      if (wr && m_pend == 0) begin m_thr = thr; m_units = un; end
      if (v) m_pend++;
      if (ack) m_irq = 0;
    end
    @(negedge clk);
    check(req, irq, m_irq);
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) cyc(req, 0, 0, 0, 0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: irq=%0b expected run end", irq);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmpl_valid = 0; cmpl_tag = 0; unit_tick = 0; cfg_wr = 0;
    cfg_thresh = 0; cfg_units = 0; irq_ack = 0;
    m_thr = 0; m_units = 0; m_pend = 0; m_tmr = 0; m_irq = 0;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check("R1 in reset", irq, 0);
    rst_n = 1;
    idle("R1 after reset", 2);

    // R1/R2: reset state has coalescing off
    cyc("R2 default after reset", 1, 0, 0, 0);
    idle("R8 level held", 3);
    cyc("R8 ack", 0, 0, 0, 1);
    // R2 with threshold 1
    cyc("R2 cfg thr1", 0, 0, 0, 0, 1, 1, 0);
    cyc("R2 thr1 fire", 1, 0, 0, 1);
    cyc("R8 ack", 0, 0, 0, 1);
    cyc("R2 thr1 fire again", 1, 0, 0, 0);
    cyc("R8 ack with fire keeps", 1, 0, 0, 1);
    cyc("R8 ack", 0, 0, 0, 1);

    // R3 and R10: threshold 4, no timeout
    cyc("R3 cfg", 0, 0, 0, 0, 1, 4, 0);
    for (int i = 0; i < 3; i++) cyc("R3 below threshold", 1, 0, 1, 0);
    for (int i = 0; i < 20; i++) cyc("R10 ticks no timeout", 0, 0, 1, 0);
    cyc("R3 fourth completion", 1, 0, 0, 0);
    cyc("R8 ack", 0, 0, 0, 1);

    // R4: threshold 8, timeout 3
    cyc("R4 cfg", 0, 0, 0, 0, 1, 8, 3);
    cyc("R4 first pending, tick ignored", 1, 0, 1, 0);
    cyc("R4 tick1", 0, 0, 1, 0);
    cyc("R4 gap", 1, 0, 0, 0);
    cyc("R4 tick2", 0, 0, 1, 0);
    cyc("R4 tick3 expire", 0, 0, 1, 0);
    cyc("R8 ack", 0, 0, 0, 1);

    // R5, R6, R7
    cyc("R7 cfg", 0, 0, 0, 0, 1, 8, 0);
    cyc("R5 pending", 1, 0, 0, 0);
    cyc("R5 pending", 1, 0, 0, 0);
    cyc("R5 urgent 01", 1, 1, 0, 0);
    cyc("R8 ack", 0, 0, 0, 1);
    for (int i = 0; i < 7; i++) cyc("R7 fresh batch", 1, 0, 0, 0);
    cyc("R5 urgent 11", 1, 3, 0, 0);
    cyc("R8 ack", 0, 0, 0, 1);
    cyc("R6 pending", 1, 0, 0, 0);
    cyc("R6 batch end 10", 1, 2, 0, 0);
    cyc("R8 ack", 0, 0, 0, 1);
    for (int i = 0; i < 7; i++) cyc("R6 flushed", 1, 0, 0, 0);
    cyc("R6 eighth", 1, 0, 0, 1);
    cyc("R8 ack", 0, 0, 0, 1);

    // R9: write refused while pending
    cyc("R9 pending", 1, 0, 0, 0);
    cyc("R9 pending", 1, 0, 0, 0);
    cyc("R9 refused write", 0, 0, 0, 0, 1, 1, 1);
    cyc("R9 still coalescing", 1, 0, 1, 0);
    cyc("R9 no timeout", 0, 0, 1, 0);
    cyc("R9 urgent drain", 1, 1, 0, 0);
    cyc("R8 ack", 0, 0, 0, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 3) == 0;
      int tg = (($urandom % 8) == 0) ? int'($urandom % 4) : 0;
      bit tk = ($urandom % 4) == 0;
      bit wr = ($urandom % 25) == 0;
      bit ak = m_irq && (($urandom % 3) == 0);
      cyc("random R3,R4,R7,R8", v, tg, tk, ak, wr,
          int'($urandom % 11), int'($urandom % 6));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule